// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Sequencer

This block turns single-byte read and write requests from synchronous logic into correctly timed strobe sequences for an asynchronous static RAM with active-low chip enable, output enable and write enable. A request is offered with a valid/ready handshake. It carries an address, a direction bit and, for writes, a data byte. Reads return their byte with a one-cycle response strobe. Every timing interval the memory needs is a parameter counted in clock cycles: address setup, write pulse, write hold, read access, read hold, recovery and minimum cycle time.

A write brings chip enable and write enable low together, so the write window is framed by the later falling edge and the earlier rising edge of the two strobes. Output enable stays high for the whole write. The data bus is driven from the start of the pulse until the write hold count expires. A read holds chip enable and output enable low for the longest of the three access counts and samples the bus in the last cycle of that window. A protect input from a power supervisor stops new requests from being accepted, but an access already under way always finishes.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ce_n, oe_n and we_n are 1, mem_dq_oe is 0, rsp_valid is 0, and req_ready is 1 once reset is low.
- R2: A request is taken on a rising clock edge where req_valid and req_ready are both 1. req_ready is 1 only when the block is idle and protect is 0. Transactions reach the memory in the order they were accepted, each with its own address and direction (write when req_write is 1).
- R3: A write holds the address for T_AS cycles with all strobes high. It then drives ce_n and we_n low in the same cycle for exactly T_WP cycles and raises both together. oe_n stays 1 during the whole write.
- R4: In a write, mem_dq_oe is 1 with the request's data on mem_dq_out for the whole pulse and for exactly T_WH cycles after the strobes rise. At all other times mem_dq_oe is 0.
- R5: A read keeps ce_n and oe_n low and we_n high for exactly max(T_AA, T_ACE, T_OE) cycles. It samples mem_dq_in at the clock edge that ends that window. rsp_valid is 1 for exactly one cycle, starting at that same edge, with the sampled byte on rsp_rdata. Writes produce no response.
- R6: mem_addr does not change while ce_n is low or while write data is still driven after a write.
- R7: Successive falling edges of ce_n are at least T_CYC cycles apart. In the cycle before each falling edge, all strobes are high and the bus is released.
- R8: While protect is 1, no request is accepted and no new access starts. An access accepted before protect rose completes with all its phases and, for a read, its response.
- R9: we_n and oe_n are never low at the same time, and mem_dq_oe is never 1 while oe_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| protect | input | 1 | Supervisor write-protect / stop-accepting |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Read data |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_oe | output | 1 | Drive enable for the data bus tri-state buffer |
| mem_dq_out | output | DW | Data to the bus while driven |
| mem_dq_in | input | DW | Data from the bus |

## Verification
Two of the block's functions can fall in the same cycle. The protect input can rise in the same cycle in which a read is already past acceptance and about to drop its strobes, while a second request is waiting on the handshake. This is provoked by raising protect one cycle after a read is taken, with a write held valid. The bench then judges that the read still runs its full access window and returns the right byte, that exactly one chip-enable fall occurs across forty protected cycles, and that the held write is taken only once protect drops. A second overlap is the read capture edge, which is also the edge where the strobes rise and the response appears. The bench's memory model returns the inverted byte until the access count has been reached, so a capture one cycle early is seen as wrong data.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_RHOLD,
    ST_RECOV
  } seq_state_t;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
`timescale 1ns/1ps
// Loadable down-counter that times each phase of an access.
module sram_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_datapath.sv
`timescale 1ns/1ps
// Request latch, write-data register and read capture.
module sram_seq_datapath #(
  parameter int AW = 21,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] mem_dq_in,
  output logic          op_write,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_write   <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= capture;
      if (accept) begin
        op_write   <= req_write;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      if (capture) begin
        rsp_rdata <= mem_dq_in;
      end
    end
  end

  // R5: the response strobe never lasts more than one cycle
  assert_rsp_single_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: no new address is latched unless a request is accepted
  assert_addr_only_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(accept) |-> $stable(mem_addr));
endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer for single-byte accesses to an asynchronous SRAM.
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int AW    = 21,
  parameter int DW    = 8,
  parameter int T_AS  = 1,   // address setup before strobes fall
  parameter int T_WP  = 11,  // write pulse width
  parameter int T_WH  = 3,   // address/data hold after write strobes rise
  parameter int T_RH  = 1,   // address hold after read strobes rise
  parameter int T_REC = 1,   // minimum strobes-high recovery
  parameter int T_CYC = 14,  // minimum chip-enable fall-to-fall period
  parameter int T_AA  = 14,  // address access
  parameter int T_ACE = 14,  // chip enable access
  parameter int T_OE  = 7    // output enable access
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          protect,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_dq_oe,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int ACC_LEN = max_i(max_i(T_AA, T_ACE), max_i(T_OE, 1));
  localparam int W_SPAN  = T_AS + T_WP + T_WH + 1;
  localparam int R_SPAN  = T_AS + ACC_LEN + T_RH + 1;
  localparam int W_REC   = max_i(T_CYC - W_SPAN, max_i(T_REC, 1));
  localparam int R_REC   = max_i(T_CYC - R_SPAN, max_i(T_REC, 1));
  localparam int MAX_LEN = max_i(max_i(max_i(T_AS, T_WP), max_i(T_WH, T_RH)),
                                 max_i(max_i(W_REC, R_REC), ACC_LEN));
  localparam int CW      = $clog2(MAX_LEN + 1);

  localparam logic [CW-1:0] LD_AS  = CW'(T_AS - 1);
  localparam logic [CW-1:0] LD_WP  = CW'(T_WP - 1);
  localparam logic [CW-1:0] LD_WH  = CW'(T_WH - 1);
  localparam logic [CW-1:0] LD_RH  = CW'(T_RH - 1);
  localparam logic [CW-1:0] LD_ACC = CW'(ACC_LEN - 1);
  localparam logic [CW-1:0] LD_WRC = CW'(W_REC - 1);
  localparam logic [CW-1:0] LD_RRC = CW'(R_REC - 1);

  seq_state_t    st_q, st_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          accept, capture, op_write;

  assign req_ready = (st_q == ST_IDLE) && !protect;
  assign accept    = req_valid && req_ready;
  assign capture   = (st_q == ST_RACC) && tmr_done;

  sram_seq_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_seq_datapath #(.AW(AW), .DW(DW)) dpath_i (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .capture    (capture),
    .mem_dq_in  (mem_dq_in),
    .op_write   (op_write),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // Phase sequencing; every phase lasts (load value + 1) cycles.
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = LD_AS;
      end
      ST_SETUP: if (tmr_done) begin
        tmr_load = 1'b1;
        if (op_write) begin st_d = ST_WPULSE; tmr_val = LD_WP;  end
        else          begin st_d = ST_RACC;   tmr_val = LD_ACC; end
      end
      ST_WPULSE: if (tmr_done) begin
        st_d = ST_WHOLD; tmr_load = 1'b1; tmr_val = LD_WH;
      end
      ST_WHOLD: if (tmr_done) begin
        st_d = ST_RECOV; tmr_load = 1'b1; tmr_val = LD_WRC;
      end
      ST_RACC: if (tmr_done) begin
        st_d = ST_RHOLD; tmr_load = 1'b1; tmr_val = LD_RH;
      end
      ST_RHOLD: if (tmr_done) begin
        st_d = ST_RECOV; tmr_load = 1'b1; tmr_val = LD_RRC;
      end
      ST_RECOV: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next phase so they change on clock edges only.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st_q      <= st_d;
      mem_ce_n  <= !((st_d == ST_WPULSE) || (st_d == ST_RACC));
      mem_we_n  <= !(st_d == ST_WPULSE);
      mem_oe_n  <= !(st_d == ST_RACC);
      mem_dq_oe <= (st_d == ST_WPULSE) || (st_d == ST_WHOLD);
    end
  end

  // R9: write enable and output enable never overlap
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));
  // R9: bus driven only while the memory outputs are off
  assert_drive_vs_oe_R9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  // R3: write enable low only inside chip enable low
  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);
  // R3: write pulse carries driven data
  assert_pulse_has_data_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);
  // R6: address stable over chip-enable low and data hold
  assert_addr_hold_ce_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
  assert_addr_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_addr));
  // R7: an access starts only from a fully quiet bus
  assert_idle_before_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> ($past(mem_we_n) && $past(mem_oe_n) && !$past(mem_dq_oe)));
  // R8: protect blocks the handshake
  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    protect |-> !req_ready);
endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;
  localparam int AW = 4, DW = 8;
  localparam int T_AS = 1, T_WP = 3, T_WH = 2, T_RH = 1, T_REC = 1, T_CYC = 9;
  localparam int T_AA = 4, T_ACE = 3, T_OE = 2;
  localparam int ACC = 4;
  localparam int NWORDS = 1 << AW;
  localparam int WDOG = 100000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, protect = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_seq_ctrl #(.AW(AW), .DW(DW), .T_AS(T_AS), .T_WP(T_WP), .T_WH(T_WH),
    .T_RH(T_RH), .T_REC(T_REC), .T_CYC(T_CYC), .T_AA(T_AA), .T_ACE(T_ACE),
    .T_OE(T_OE)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .protect(protect), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in));

  // bench-side expectations and issue record
  logic [DW-1:0] exp_mem [NWORDS];
  logic [DW-1:0] sram_arr [NWORDS];
  int  iss_addr [256];
  logic iss_wr [256];
  int  wp = 0, rp = 0, n_reads = 0;
  int  n_checks = 0, n_err = 0, m_checks = 0, m_err = 0;
  int  cyc = 0;
  logic rd_ok = 1'b0;

  // memory model: returns the inverted byte until the access count is met
  assign mem_dq_in = rd_ok ? sram_arr[mem_addr] : ~sram_arr[mem_addr];

  function automatic logic [DW-1:0] pat(input int a, input int p);
    return DW'((a * 29 + 7 + p * 101) & 255);
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic mcheck(input string tag, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
    m_checks++;
    if (act !== exp) begin
      m_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      $display("FAIL R2 watchdog: actual=%0d expected=<%0d", cyc, WDOG);
      $display("  Result: errors=%0d of %0d checks", n_err + m_err + 1, n_checks + m_checks + 1);
      $finish;
    end
  end

  // monitor, sampled on the falling edge
  logic pce = 1, pwe = 1, poe = 1, pdq = 0;
  logic cur_wr = 0, in_hold = 0, bad3 = 0, bad4 = 0, bad6 = 0, bad9 = 0, stray = 0;
  int cur_a = 0, rd_lat = 0, wcnt = 0, rcnt = 0, hcnt = 0, last_fall = 0;
  int n_falls = 0, n_rsp = 0;
  logic [DW-1:0] lat_d = '0;

  initial for (int i = 0; i < NWORDS; i++) begin
    exp_mem[i] = '0;
    sram_arr[i] = '0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (pce && !mem_ce_n) begin
        if (n_falls > 0) mcheck("R7", (cyc - last_fall) >= T_CYC, 1, "ce fall spacing ok");
        mcheck("R7", pwe && poe && !pdq, 1, "quiet cycle before start");
        last_fall = cyc; n_falls++;
        mcheck("R2", mem_addr, iss_addr[rp], "address order");
        mcheck("R2", !mem_we_n, iss_wr[rp], "direction order");
        cur_wr = iss_wr[rp]; cur_a = iss_addr[rp]; rp++;
        if (!cur_wr) rd_lat = cur_a;
        wcnt = 0; rcnt = 0; bad3 = 0; bad4 = 0; bad6 = 0;
      end
      if (!mem_we_n && !mem_oe_n) bad9 = 1;
      if (mem_dq_oe && !mem_oe_n) bad9 = 1;
      if (!mem_ce_n) begin
        if (32'(mem_addr) != cur_a) bad6 = 1;
        if (cur_wr) begin
          wcnt++;
          if (mem_we_n !== 1'b0 || mem_oe_n !== 1'b1) bad3 = 1;
          if (mem_dq_oe !== 1'b1 || mem_dq_out !== exp_mem[cur_a]) bad4 = 1;
          lat_d = mem_dq_out;
        end else begin
          rcnt++;
          if (mem_oe_n !== 1'b0 || mem_we_n !== 1'b1 || mem_dq_oe) bad3 = 1;
        end
      end
      rd_ok = !mem_ce_n && !mem_oe_n && (rcnt >= ACC);
      if (!pce && mem_ce_n) begin
        if (cur_wr) begin
          mcheck("R3", wcnt, T_WP, "write pulse cycles");
          mcheck("R3", bad3, 0, "write strobe shape");
          mcheck("R3", mem_we_n, 1, "we rises with ce");
          sram_arr[cur_a] = lat_d;
          hcnt = 0; in_hold = 1;
        end else begin
          mcheck("R5", rcnt, ACC, "read access cycles");
          mcheck("R5", bad3, 0, "read strobe shape");
          mcheck("R5", rsp_valid, 1, "response at strobe rise");
        end
        mcheck("R9", bad9, 0, "no bus contention");
        bad9 = 0;
      end
      if (mem_ce_n && in_hold) begin
        if (mem_dq_oe) begin
          hcnt++;
          if (32'(mem_addr) != cur_a || !mem_we_n || !mem_oe_n) bad6 = 1;
        end else begin
          mcheck("R4", hcnt, T_WH, "data hold cycles");
          mcheck("R4", bad4, 0, "data driven over pulse");
          mcheck("R6", bad6, 0, "address held");
          in_hold = 0;
        end
      end else if (mem_ce_n && !cur_wr && !pce) begin
        mcheck("R6", bad6, 0, "read address held");
      end
      if (mem_ce_n && !in_hold && mem_dq_oe) stray = 1;
      if (rsp_valid) begin
        n_rsp++;
        mcheck("R5", rsp_rdata, exp_mem[rd_lat], "read data");
      end
      pce = mem_ce_n; pwe = mem_we_n; poe = mem_oe_n; pdq = mem_dq_oe;
    end
  end

  // call and return on a falling edge
  task automatic do_req(input logic w, input int a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    iss_addr[wp] = a; iss_wr[wp] = w; wp++;
    if (w) exp_mem[a] = d; else n_reads++;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", req_ready, 0, "ready drops after accept");
  endtask

  initial begin
    int f0, r0;
    repeat (3) @(negedge clk);
    check("R1", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111, "strobes in reset");
    check("R1", {mem_dq_oe, rsp_valid}, 2'b00, "bus/resp in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110, "after reset");
    check("R1", req_ready, 1, "ready after reset");

    // sweep: fill every word, read it all back back-to-back
    for (int a = 0; a < NWORDS; a++) do_req(1'b1, a, pat(a, 0));
    for (int a = 0; a < NWORDS; a++) do_req(1'b0, a, '0);
    // interleaved write/read with a second pattern
    for (int a = 0; a < NWORDS; a++) begin
      do_req(1'b1, a, pat(a, 1));
      do_req(1'b0, a, '0);
      do_req(1'b0, (a + 5) % NWORDS, '0);
    end

    // protect rises while a read is under way and a write waits
    do_req(1'b0, 3, '0);
    protect = 1'b1;
    f0 = n_falls; r0 = n_rsp;
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(9); req_wdata = 8'hC3;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R8", req_ready, 0, "ready held low under protect");
    end
    check("R8", n_falls - f0, 1, "only the started access ran");
    check("R8", n_rsp - r0, 1, "started read completed");
    iss_addr[wp] = 9; iss_wr[wp] = 1'b1; wp++;
    exp_mem[9] = 8'hC3;
    protect = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8", req_ready, 0, "held write taken after protect");
    do_req(1'b0, 9, '0);
    for (int a = 0; a < NWORDS; a++) do_req(1'b0, NWORDS - 1 - a, '0);

    repeat (30) @(negedge clk);
    check("R5", n_rsp, n_reads, "one response per read");
    check("R2", rp, wp, "every request reached memory");
    check("R4", stray, 0, "bus released outside writes");
    check("R7", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110, "quiet at end");
    $display("  Result: errors=%0d of %0d checks", n_err + m_err, n_checks + m_checks);
    $finish;
  end
endmodule